// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block gives a host on a two-wire serial bus (I2C protocol) access to a small register space at the top of the byte address range. It holds eight configuration bytes: four ramp-profile bytes, three control bytes and one reserved byte. Above them sit eight bytes of user memory. Software selects a byte with a memory-address byte. It then either writes one or more data bytes, or issues a repeated start and reads bytes back. The bus pointer advances after every byte.

SCL and the SDA line are oversampled in the system clock domain. The slave pulls SDA low through an open-drain enable. The low bit of the slave address comes from a strap pin, so two devices can share a bus. The configuration bytes drive the rest of the chip in parallel.

Stored data models a nonvolatile array. After any transfer that changed a byte, the slave stays deaf to its own address for a programmable number of clock cycles. User memory is write-locked until a control bit allows changes.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The 7-bit slave address is binary 101000 followed by `addr_sel`, and the R/W flag is bit 0 of the address byte (0 = write, 1 = read). A matching address is acknowledged (SDA low on the 9th clock) when no write-busy period runs. Any other address is not acknowledged.
- R2: After a non-matching address byte the slave drives no SDA and changes no register until the next start condition.
- R3: A write is the address byte, then a memory-address byte, then data bytes, each sent MSB first and each acknowledged. A data byte for a writable configuration byte appears on `cfg_q` before the stop condition.
- R4: A random read is a memory-address write, a repeated start, and the address byte with R/W = 1. The slave then returns data MSB first. A master NACK ends the read and the slave releases SDA.
- R5: The internal pointer increments after every data byte written or read, so consecutive bytes in one transfer reach consecutive addresses.
- R6: The slave changes SDA only after an SCL falling edge. A bit it drives stays stable while SCL is high.
- R7: After the stop of a transfer that stored at least one byte, the slave does not acknowledge its own address for BUSY_CYCLES clock cycles. After that it acknowledges again.
- R8: User memory at F8h–FFh resets to 00h. Writes to it are acknowledged but discarded while bit 0 of the byte at F5h is 0, and stored when that bit is 1.
- R9: Reset values for F0h..F7h are 21h, 43h, 65h, 77h, 00h, 08h, 00h, 00h. Byte F0h+k drives `cfg_q[8k+7:8k]`.
- R10: A data byte for an address below F0h is not acknowledged and nothing is stored. Reads from such addresses return 00h.
- R11: A write-busy period starts only when a byte was stored. A transfer whose writes were all blocked, refused, reserved or address-only leaves the slave free at once.
- R12: The reserved byte F7h acknowledges writes, discards them, and always reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| addr_sel | input | 1 | Strap pin giving the slave address LSB |
| cfg_q | output | 64 | Configuration bytes F0h..F7h, byte k at bits 8k+7:8k |

## Verification
The bench builds the block with a write-busy length of 300 cycles. A busy window that short can be seen opening, refusing an address byte, and closing again within a few transfers. This makes both sides of R7 and R11 cheap to reach. Two synchroniser stages and an 8-cycle half bit period on SCL put every SDA change a few cycles after the falling edge. The bench therefore samples early and late in each high phase to catch a bit that moves while SCL is high. The default window and address prefix are kept, so the reset values, the write lock, the reserved byte and the region below the window are all reached through bus traffic alone.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DEV,
      S_MADDR,
      S_WDATA,
      S_ACK,
      S_TX,
      S_RACK
   } cfg_st_e;

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic [STAGES-1:0] scl_p, sda_p;
   logic              scl_d, sda_d;

   generate
      if (STAGES < 1) begin : g_bad
         $error("cfg_i2c_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p <= scl_i;
               sda_p <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p <= {scl_p[STAGES-2:0], scl_i};
               sda_p <= {sda_p[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_lvl = scl_p[STAGES-1];
   assign sda_lvl = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_rise = scl_lvl & ~scl_d;
   assign scl_fall = ~scl_lvl & scl_d;
   assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/cfg_i2c_store.sv
module cfg_i2c_store #(
   parameter int                       CFG_BYTES  = 8,
   parameter int                       USER_BYTES = 8,
   parameter int                       RSV_IDX    = 7,
   parameter int                       WP_IDX     = 5,
   parameter int                       WP_BIT     = 0,
   parameter logic [8*CFG_BYTES-1:0]   CFG_RESET  = '0,
   localparam int                      AW = $clog2(CFG_BYTES + USER_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            idx,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   output logic                     accept,
   output logic [8*CFG_BYTES-1:0]   cfg_q
);

   logic [8*USER_BYTES-1:0] user_q;
   logic                    wp_en;
   logic                    in_cfg;

   generate
      if (WP_IDX >= CFG_BYTES || WP_BIT > 7) begin : g_bad_wp
         $error("cfg_i2c_store: write-enable bit lies outside the configuration bytes");
      end
   endgenerate

   assign wp_en  = cfg_q[8*WP_IDX + WP_BIT];
   assign in_cfg = idx < AW'(CFG_BYTES);
   assign accept = we && (in_cfg ? (idx != AW'(RSV_IDX)) : wp_en);

   generate
      for (genvar i = 0; i < CFG_BYTES; i++) begin : g_cfg
         if (i == RSV_IDX) begin : g_rsv
            assign cfg_q[8*i +: 8] = 8'h00;
         end else begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cfg_q[8*i +: 8] <= CFG_RESET[8*i +: 8];
               else if (accept && idx == AW'(i))
                  cfg_q[8*i +: 8] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_q <= '0;
      end else begin
         for (int k = 0; k < USER_BYTES; k++)
            if (accept && idx == AW'(CFG_BYTES + k))
               user_q[8*k +: 8] <= wdata;
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int k = 0; k < CFG_BYTES; k++)
         if (idx == AW'(k)) rdata = cfg_q[8*k +: 8];
      for (int k = 0; k < USER_BYTES; k++)
         if (idx == AW'(CFG_BYTES + k)) rdata = user_q[8*k +: 8];
   end

   // R8: a locked user-memory write leaves the user bytes unchanged
   p_user_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !in_cfg && !wp_en) |=> $stable(user_q));

   // R3: configuration bytes move only on a write strobe
   p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
   import cfg_i2c_pkg::*;
#(
   parameter logic [5:0] DEV_PREFIX  = 6'b101000,
   parameter int         BUSY_CYCLES = 50000,
   parameter logic [7:0] WIN_BASE    = 8'hF0,
   parameter int         WIN_BYTES   = 16,
   parameter int         AW          = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_ev,
   input  logic          stop_ev,
   input  logic          addr_sel,
   input  logic [7:0]    rdata,
   input  logic          accept,
   output logic          we,
   output logic [AW-1:0] idx,
   output logic [7:0]    wdata,
   output logic          sda_oe
);

   localparam int             BW        = $clog2(BUSY_CYCLES + 1);
   localparam logic [BW-1:0]  BUSY_LOAD = BW'(BUSY_CYCLES);

   cfg_st_e        st, nxt;
   logic [3:0]     cnt;
   logic [7:0]     sh;
   logic [6:0]     tx;
   logic [7:0]     ptr, off, byte_out;
   logic           wrote, in_win, last_rx;
   logic [BW-1:0]  busy_cnt;

   assign off      = ptr - WIN_BASE;
   assign in_win   = {1'b0, off} < 9'(WIN_BYTES);
   assign idx      = off[AW-1:0];
   assign byte_out = in_win ? rdata : 8'h00;
   assign last_rx  = scl_fall && (cnt == 4'd8);
   assign we       = (st == S_WDATA) && last_rx && in_win;
   assign wdata    = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         nxt      <= S_IDLE;
         cnt      <= '0;
         sh       <= '0;
         tx       <= '0;
         ptr      <= '0;
         wrote    <= 1'b0;
         sda_oe   <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
         if (start_ev) begin
            st     <= S_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
            if (wrote) busy_cnt <= BUSY_LOAD;
         end else begin
            unique case (st)
               S_DEV, S_MADDR, S_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (last_rx) begin
                     cnt <= '0;
                     if (st == S_DEV) begin
                        if (sh[7:1] == {DEV_PREFIX, addr_sel} && busy_cnt == '0) begin
                           sda_oe <= 1'b1;
                           nxt    <= sh[0] ? S_TX : S_MADDR;
                           st     <= S_ACK;
                        end else begin
                           st <= S_IDLE;
                        end
                     end else if (st == S_MADDR) begin
                        ptr    <= sh;
                        sda_oe <= 1'b1;
                        nxt    <= S_WDATA;
                        st     <= S_ACK;
                     end else begin
                        ptr <= ptr + 1'b1;
                        if (in_win) begin
                           sda_oe <= 1'b1;
                           nxt    <= S_WDATA;
                           st     <= S_ACK;
                           wrote  <= wrote | accept;
                        end else begin
                           st <= S_IDLE;
                        end
                     end
                  end
               end
               S_ACK: begin
                  if (scl_fall) begin
                     if (nxt == S_TX) begin
                        tx     <= byte_out[6:0];
                        sda_oe <= ~byte_out[7];
                        cnt    <= '0;
                        ptr    <= ptr + 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                     end
                     st <= nxt;
                  end
               end
               S_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        st     <= S_RACK;
                     end else begin
                        sda_oe <= ~tx[6];
                        tx     <= {tx[5:0], 1'b0};
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               S_RACK: begin
                  if (scl_rise) begin
                     if (sda_lvl) begin
                        st <= S_IDLE;
                     end else begin
                        nxt <= S_TX;
                        st  <= S_ACK;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R6: the slave starts pulling SDA only while SCL was low
   p_oe_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_lvl));

   // R2: an idle slave leaves SDA alone
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !sda_oe);

   // R7: an address byte arriving during the busy window is refused
   p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEV && last_rx && busy_cnt != '0 && !start_ev && !stop_ev)
         |=> (st == S_IDLE && !sda_oe));

   // R11: the busy window opens only at a stop condition
   p_busy_from_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_cnt != '0) |-> $past(stop_ev));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter int         BUSY_CYCLES = 50000,
   parameter logic [5:0] DEV_PREFIX  = 6'b101000,
   parameter logic [7:0] WIN_BASE    = 8'hF0,
   parameter int         CFG_BYTES   = 8,
   parameter int         USER_BYTES  = 8,
   parameter int         RSV_IDX     = 7,
   parameter int         WP_IDX      = 5,
   parameter int         WP_BIT      = 0,
   parameter logic [8*CFG_BYTES-1:0] CFG_RESET =
      {8'h00, 8'h00, 8'h08, 8'h00, 8'h77, 8'h65, 8'h43, 8'h21}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   input  logic                   addr_sel,
   output logic [8*CFG_BYTES-1:0] cfg_q
);

   localparam int WIN_BYTES = CFG_BYTES + USER_BYTES;
   localparam int AW        = $clog2(WIN_BYTES);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("cfg_i2c_slave: BUSY_CYCLES must be positive");
      end
      if (int'(WIN_BASE) + WIN_BYTES > 256) begin : g_bad_win
         $error("cfg_i2c_slave: register window runs past address FFh");
      end
      if ((1 << AW) != WIN_BYTES) begin : g_bad_size
         $error("cfg_i2c_slave: window size must be a power of two");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
   logic we, accept;
   logic [AW-1:0] idx;
   logic [7:0] wdata, rdata;

   cfg_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   cfg_i2c_ctrl #(
      .DEV_PREFIX  (DEV_PREFIX),
      .BUSY_CYCLES (BUSY_CYCLES),
      .WIN_BASE    (WIN_BASE),
      .WIN_BYTES   (WIN_BYTES),
      .AW          (AW)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .addr_sel (addr_sel),
      .rdata    (rdata),
      .accept   (accept),
      .we       (we),
      .idx      (idx),
      .wdata    (wdata),
      .sda_oe   (sda_oe)
   );

   cfg_i2c_store #(
      .CFG_BYTES  (CFG_BYTES),
      .USER_BYTES (USER_BYTES),
      .RSV_IDX    (RSV_IDX),
      .WP_IDX     (WP_IDX),
      .WP_BIT     (WP_BIT),
      .CFG_RESET  (CFG_RESET)
   ) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .idx    (idx),
      .wdata  (wdata),
      .rdata  (rdata),
      .accept (accept),
      .cfg_q  (cfg_q)
   );

endmodule

// File: tb/test_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_cfg_i2c_slave;

   localparam int H    = 8;
   localparam int BUSY = 300;
   localparam logic [7:0] DW = 8'hA0, DR = 8'hA1;
   localparam logic [63:0] DEF = 64'h0000_0800_7765_4321;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
   logic sda_oe, sda_line;
   logic [63:0] cfg_q;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [7:0] exp_v[$];
   string      exp_t[$];
   logic [7:0] obs_v[$];

   always #2 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   cfg_i2c_slave #(.BUSY_CYCLES(BUSY)) i_cfg_i2c_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .addr_sel (addr_sel),
      .cfg_q    (cfg_q)
   );

   // scoreboard monitor: pairs each observation with the oldest expectation
   initial begin
      forever begin
         @(negedge clk);
         while (obs_v.size() > 0) begin
            logic [7:0] o;
            o = obs_v.pop_front();
            checks++;
            if (exp_v.size() == 0) begin
               fails++;
               $display("FAIL unexpected result: actual %02h expected none", o);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_v.pop_front();
               t = exp_t.pop_front();
               if (o !== e) begin
                  fails++;
                  $display("FAIL %s: actual %02h expected %02h", t, o, e);
               end
            end
         end
      end
   end

   task automatic ex(input logic [7:0] v, input string t);
      exp_v.push_back(v);
      exp_t.push_back(t);
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start;
      m_sda = 1'b1; hw(H);
      scl   = 1'b1; hw(H);
      m_sda = 1'b0; hw(H);
      scl   = 1'b0; hw(2);
   endtask

   task automatic i2c_stop;
      m_sda = 1'b0; hw(H);
      scl   = 1'b1; hw(H);
      m_sda = 1'b1; hw(H);
   endtask

   task automatic send(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; hw(H);
         scl = 1'b1;   hw(H);
         scl = 1'b0;   hw(2);
      end
      m_sda = 1'b1; hw(H);
      scl = 1'b1;   hw(H/2);
      obs_v.push_back({7'd0, sda_line});
      hw(H/2);
      scl = 1'b0;   hw(2);
   endtask

   task automatic recv(input logic nack);
      logic [7:0] v;
      logic       stable, s0;
      v = '0;
      stable = 1'b1;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         hw(H);
         scl = 1'b1; hw(1);
         s0 = sda_line; hw(H-2);
         if (sda_line !== s0) stable = 1'b0;
         v = {v[6:0], s0};
         hw(1);
         scl = 1'b0; hw(2);
      end
      obs_v.push_back(v);
      obs_v.push_back({7'd0, stable});
      m_sda = nack; hw(H);
      scl = 1'b1;   hw(H);
      scl = 1'b0;   hw(2);
      m_sda = 1'b1;
   endtask

   task automatic obs_cfg(input int k);
      obs_v.push_back(cfg_q[8*k +: 8]);
   endtask

   initial begin
      hw(10);
      rst_n = 1'b1;
      hw(10);

      // R9: reset values on the parallel outputs
      for (int k = 0; k < 8; k++) begin
         ex(DEF[8*k +: 8], "R9 reset value on cfg_q");
         obs_cfg(k);
      end

      // R4 R5 R9: random read of four profile bytes
      i2c_start;
      ex(0, "R1 own address acked"); send(DW);
      ex(0, "R4 memory address acked"); send(8'hF0);
      i2c_start;
      ex(0, "R4 read address acked"); send(DR);
      for (int k = 0; k < 4; k++) begin
         ex(DEF[8*k +: 8], "R5 sequential read value");
         ex(1, "R6 bit stable while SCL high");
         recv(k == 3);
      end
      i2c_stop;

      // R1 R2: foreign address refused, rest of transfer ignored
      i2c_start;
      ex(1, "R1 foreign address nacked"); send(8'hA2);
      ex(1, "R2 ignored memory byte"); send(8'hF4);
      ex(1, "R2 ignored data byte"); send(8'hFF);
      i2c_stop;
      ex(8'h00, "R2 no register change"); obs_cfg(4);

      // R3: single byte write
      i2c_start;
      ex(0, "R3 address acked"); send(DW);
      ex(0, "R3 memory address acked"); send(8'hF4);
      ex(0, "R3 data acked"); send(8'h5A);
      i2c_stop;
      ex(8'h5A, "R3 byte on cfg_q"); obs_cfg(4);

      // R7: busy window refuses own address, then ends
      i2c_start;
      ex(1, "R7 busy address nacked"); send(DW);
      i2c_stop;
      hw(BUSY + 50);
      i2c_start;
      ex(0, "R7 address acked after busy"); send(DW);
      ex(0, "R8 memory address acked"); send(8'hF8);
      ex(0, "R8 locked write acked"); send(8'h11);
      i2c_stop;

      // R8 R11: locked write stored nothing and started no busy period
      i2c_start;
      ex(0, "R11 no busy after locked write"); send(DW);
      ex(0, "R8 memory address acked"); send(8'hF8);
      i2c_start;
      ex(0, "R8 read address acked"); send(DR);
      ex(8'h00, "R8 locked user byte unchanged"); ex(1, "R6 bit stable");
      recv(1'b1);
      i2c_stop;

      // R8 R5: unlock user memory, then a two-byte burst
      i2c_start;
      ex(0, "R8 address acked"); send(DW);
      ex(0, "R8 memory address acked"); send(8'hF5);
      ex(0, "R8 unlock data acked"); send(8'h09);
      i2c_stop;
      hw(BUSY + 50);
      i2c_start;
      ex(0, "R5 address acked"); send(DW);
      ex(0, "R5 memory address acked"); send(8'hF8);
      ex(0, "R5 first data acked"); send(8'h11);
      ex(0, "R5 second data acked"); send(8'h22);
      i2c_stop;
      hw(BUSY + 50);
      i2c_start;
      ex(0, "R5 address acked"); send(DW);
      ex(0, "R5 memory address acked"); send(8'hF8);
      i2c_start;
      ex(0, "R5 read address acked"); send(DR);
      ex(8'h11, "R8 unlocked user byte stored"); ex(1, "R6 bit stable");
      recv(1'b0);
      ex(8'h22, "R5 incremented write and read"); ex(1, "R6 bit stable");
      recv(1'b1);
      i2c_stop;

      // R10 R11: below the window
      i2c_start;
      ex(0, "R10 address acked"); send(DW);
      ex(0, "R10 memory address acked"); send(8'hE0);
      ex(1, "R10 data below window nacked"); send(8'h33);
      i2c_stop;
      i2c_start;
      ex(0, "R11 no busy after refused write"); send(DW);
      ex(0, "R10 memory address acked"); send(8'hE0);
      i2c_start;
      ex(0, "R10 read address acked"); send(DR);
      ex(8'h00, "R10 read below window"); ex(1, "R6 bit stable");
      recv(1'b1);
      i2c_stop;

      // R12: reserved byte
      i2c_start;
      ex(0, "R12 address acked"); send(DW);
      ex(0, "R12 memory address acked"); send(8'hF7);
      ex(0, "R12 reserved write acked"); send(8'hFF);
      i2c_stop;
      i2c_start;
      ex(0, "R11 no busy after reserved write"); send(DW);
      ex(0, "R12 memory address acked"); send(8'hF7);
      i2c_start;
      ex(0, "R12 read address acked"); send(DR);
      ex(8'h00, "R12 reserved reads zero"); ex(1, "R6 bit stable");
      recv(1'b1);
      i2c_stop;
      ex(8'h00, "R12 reserved output zero"); obs_cfg(7);

      // R1: strap pin moves the address
      addr_sel = 1'b1;
      hw(4);
      i2c_start;
      ex(0, "R1 strapped address acked"); send(8'hA2);
      ex(0, "R1 memory address acked"); send(8'hF4);
      i2c_start;
      ex(0, "R1 strapped read acked"); send(8'hA3);
      ex(8'h5A, "R4 read after strap"); ex(1, "R6 bit stable");
      recv(1'b1);
      i2c_stop;
      i2c_start;
      ex(1, "R1 old address nacked"); send(DW);
      i2c_stop;

      hw(20);
      while (exp_v.size() > 0) begin
         string t;
         checks++;
         fails++;
         t = exp_t.pop_front();
         $display("FAIL %s: actual none expected %02h", t, exp_v.pop_front());
      end
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule